// File: doc/BRIEF.md
# Sparse-Decode One-Second Timebase Divider

The block turns a fast reference clock into a one-pulse-per-second timebase. A free-running binary counter advances once per reference cycle. The end of each second is found by ANDing only those counter bits that are ones in the selected divide ratio, so no full equality comparator is needed. That terminal count starts a clear pulse. The pulse holds the counter at zero for a set number of cycles and then lets it resume. Each clear makes one single-cycle tick.

A two-bit select picks the divide ratio: 50,000, 100,000 or 1,000,000. A fourth setting skips decode and clear: the counter runs freely and one chosen counter bit sets the tick rate. The clear length is a parameter, so the cycles lost to the clear can be modelled exactly. Each decode period lasts the ratio plus the clear length minus one. The select is sampled once, on the first clock after reset is released, so the ratio never changes part way through a count.

Top module: `timebase_divider`

## Requirements
- R1: While reset is asserted, the counter reads zero and the terminal-count, clear and tick outputs are low.
- R2: With select 2'b00, terminal count first rises when the counter reads 50,000. It is decoded from bits 4, 6, 8, 9, 14 and 15 alone.
- R3: With select 2'b01, terminal count first rises when the counter reads 100,000. It is decoded from bits 5, 7, 9, 10, 15 and 16 alone, and does not fire at 50,000.
- R4: With select 2'b10, terminal count is decoded from bits 6, 9, 14, 16, 17, 18 and 19 alone, and does not fire at lower counts.
- R5: Terminal count lasts one cycle. The clear output is high for CLR_HOLD cycles, starting with the terminal-count cycle, and the counter reads zero in every clear cycle after the first.
- R6: In the cycle after the clear ends, the counter reads 1. The tick-to-tick period in a decode mode is therefore ratio + CLR_HOLD - 1 cycles.
- R7: The tick output is a single-cycle pulse, one cycle after terminal count in the decode modes.
- R8: With select 2'b11, terminal count and clear never assert. The tick pulses one cycle after counter bit POW2_BIT rises, every 2^(POW2_BIT+1) cycles.
- R9: The select is captured on the first clock after reset is released. Later changes have no effect until the next reset.
- R10: Outside clear cycles, and after the first clock following reset, the counter advances by exactly one per clock and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Ratio select: 00 = 50k, 01 = 100k, 10 = 1M, 11 = power-of-two bit |
| cnt_out | output | CNT_W | Current counter value |
| tc_strobe | output | 1 | Terminal-count decode, one cycle |
| clr_pulse | output | 1 | Stretched counter clear |
| tick_1hz | output | 1 | One-cycle tick per timebase period |

## Verification
A wrong decode mask shows up on tc_strobe at the exact cycle where the counter first holds the ratio. It can also show up earlier, at 50,000, in the wider modes. Because the bench counts edges from reset release, an early or late count is reported in the cycle it happens. A wrong clear length or resume value shows at cnt_out within CLR_HOLD + 1 cycles of terminal count. A select captured at the wrong time shows as a tick, or a missing tick, within one power-of-two period.

// File: rtl/timebase_divider.sv
module timebase_divider #(
  parameter int CNT_W    = 24,
  parameter int CLR_HOLD = 7,
  parameter int POW2_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  output logic [CNT_W-1:0] cnt_out,
  output logic             tc_strobe,
  output logic             clr_pulse,
  output logic             tick_1hz
);
  localparam int HW = (CLR_HOLD < 2) ? 1 : $clog2(CLR_HOLD + 1);
  localparam logic [1:0] M_50K = 2'b00, M_100K = 2'b01, M_1M = 2'b10, M_P2 = 2'b11;

  logic [CNT_W-1:0] cnt, mask;
  logic [HW-1:0]    hold;
  logic [1:0]       mode_q;
  logic             armed, bit_q, tick_q, pow2, last_clr;

  always_comb begin
    case (mode_q)
      M_50K:   mask = CNT_W'(24'h00C350);
      M_100K:  mask = CNT_W'(24'h0186A0);
      M_1M:    mask = CNT_W'(24'h0F4240);
      default: mask = '0;
    endcase
  end

  assign pow2      = (mode_q == M_P2);
  assign tc_strobe = armed & ~pow2 & (hold == '0) & (&(cnt | ~mask));
  assign clr_pulse = tc_strobe | (hold != '0);
  assign last_clr  = tc_strobe ? (CLR_HOLD == 1) : (hold == HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      hold   <= '0;
      mode_q <= M_50K;
      armed  <= 1'b0;
      bit_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (!armed) begin
      armed  <= 1'b1;
      mode_q <= mode_sel;
    end else begin
      bit_q  <= cnt[POW2_BIT];
      tick_q <= pow2 ? (cnt[POW2_BIT] & ~bit_q) : tc_strobe;
      if (tc_strobe)         hold <= HW'(CLR_HOLD - 1);
      else if (hold != '0)   hold <= hold - HW'(1);
      if (clr_pulse)         cnt  <= last_clr ? CNT_W'(1) : '0;
      else                   cnt  <= cnt + CNT_W'(1);
    end
  end

  assign cnt_out  = cnt;
  assign tick_1hz = tick_q;
endmodule

// File: rtl/timebase_divider_chk.sv
module timebase_divider_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             tc,
  input logic             clr,
  input logic             tick,
  input logic [1:0]       mode_q,
  input logic             armed
);
  AST_TC_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) tc |=> !tc);                          // R5
  AST_CLR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (clr && !tc) |-> (cnt == '0));      // R5
  AST_RESUME_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(clr) |-> (cnt == CNT_W'(1))); // R6
  AST_TICK_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n) tc |=> tick);                        // R7
  AST_TICK_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);                     // R7
  AST_POW2_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (armed && mode_q == 2'b11) |-> !clr); // R8
  AST_MODE_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (armed && $past(armed)) |-> $stable(mode_q)); // R9
  AST_COUNT_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
                       (!clr && !$past(clr) && $past(armed)) |-> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));   // R10
endmodule

bind timebase_divider timebase_divider_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_out), .tc(tc_strobe), .clr(clr_pulse),
  .tick(tick_1hz), .mode_q(mode_q), .armed(armed)
);

// File: tb/test_timebase_divider.sv
module test_timebase_divider;
  localparam int CNT_W = 24, HOLD = 7, PBIT = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [CNT_W-1:0] cnt_out;
  logic tc_strobe, clr_pulse, tick_1hz;
  int tests = 0, fails = 0;

  timebase_divider #(.CNT_W(CNT_W), .CLR_HOLD(HOLD), .POW2_BIT(PBIT)) i_timebase_divider (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cnt_out(cnt_out),
    .tc_strobe(tc_strobe), .clr_pulse(clr_pulse), .tick_1hz(tick_1hz));

  always #5 clk = ~clk;

  function automatic longint ratio_of(input logic [1:0] m);
    case (m)
      2'b00: return 50000;
      2'b01: return 100000;
      2'b10: return 1000000;
      default: return 0;
    endcase
  endfunction

  function automatic longint period_of(input logic [1:0] m);
    return ratio_of(m) + HOLD - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = m;
    repeat (2 + ($urandom % 3)) @(negedge clk);
    chk(cnt_out == '0 && !tc_strobe && !clr_pulse && !tick_1hz, "R1", cnt_out, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_decode(input logic [1:0] m, input string req);
    longint e = 0, ratio = ratio_of(m), flip_at = 10 + ($urandom % 1000);
    bit early = 0;
    do_reset(m);
    while (e < ratio + 1) begin
      @(negedge clk); e++;
      if (e == flip_at) mode_sel = 2'($urandom);
      if (e < ratio + 1 && (tc_strobe || clr_pulse || tick_1hz)) early = 1;
    end
    chk(!early, {req, " early decode"}, early, 0);
    chk(tc_strobe && cnt_out == CNT_W'(ratio), req, cnt_out, ratio);
    chk(clr_pulse, "R5 clear starts with tc", clr_pulse, 1);
    for (int k = 2; k <= HOLD; k++) begin
      @(negedge clk);
      chk(clr_pulse && !tc_strobe && cnt_out == '0, "R5 clear held", cnt_out, 0);
      if (k == 2) chk(tick_1hz, "R7 tick after tc", tick_1hz, 1);
    end
    @(negedge clk);
    chk(!clr_pulse && cnt_out == CNT_W'(1), "R6 resume at 1", cnt_out, 1);
    chk(!tick_1hz, "R7 single tick", tick_1hz, 0);
    repeat (20) @(negedge clk);
    chk(cnt_out == CNT_W'(21), "R6 period", period_of(m) - ratio + 1 + cnt_out - 1 - 20, HOLD);
  endtask

  initial begin
    void'($urandom(32'd7741));

    run_decode(2'b00, "R2");
    run_decode(2'b01, "R3");

    begin : pow2_run
      longint e = 0, t1 = -1, t2 = -1;
      bit sawclr = 0;
      do_reset(2'b11);
      while (t2 < 0 && e < 5000) begin
        @(negedge clk); e++;
        if (clr_pulse || tc_strobe) sawclr = 1;
        if (tick_1hz) begin if (t1 < 0) t1 = e; else t2 = e; end
      end
      chk(t1 == (1 << PBIT) + 2, "R8 first tick", t1, (1 << PBIT) + 2);
      chk(t2 - t1 == (2 << PBIT), "R8 spacing", t2 - t1, 2 << PBIT);
      chk(!sawclr, "R8 no clear", sawclr, 0);
    end

    begin : onemeg_run
      bit any = 0;
      do_reset(2'b10);
      for (int e = 1; e <= 3000; e++) begin
        @(negedge clk);
        if (e == 100) mode_sel = 2'b11;
        if (e == 1500) mode_sel = 2'b00;
        if (tc_strobe || clr_pulse || tick_1hz) any = 1;
      end
      chk(!any, "R4 no decode below ratio", any, 0);
      chk(!any, "R9 select change ignored", any, 0);
      chk(cnt_out == CNT_W'(2999), "R10 one step per clock", cnt_out, 2999);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 199000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule